// File: doc/BRIEF.md
# Indexed Endpoint Buffer Manager

This block holds one receive packet buffer and one transmit packet buffer for each endpoint of a USB peripheral controller. A local microcontroller reaches them through a small register bus. It first writes an index register to pick an endpoint. A one-byte control register and a 16-bit data port then act on that endpoint only. Writes to the data port fill the transmit buffer. Reads from the data port drain the receive buffer.

A transmit packet becomes sendable in one of two ways. It is validated automatically when its byte count reaches `MAX_PKT`. It can also be validated by a firmware strobe, which allows short and zero-length packets. A receive buffer empties itself once the whole packet has been read. A firmware strobe can also empty the receive buffer without touching the transmit buffer.

The token side is a simplified interface that selects an endpoint with `tk_ep`. It moves data over two valid/ready streams. On the transmit stream, `tx_valid` stays high and the beat stays stable until `tx_ready` takes it. On the receive stream, `rx_ready` is low while the selected endpoint still holds an unread packet, and a beat counts only when `rx_valid` and `rx_ready` are both high. Per-endpoint status pins show which transmit buffers are validated and which receive buffers are full.

Top module: `ep_buf_mgr`

## Requirements
- R1: After reset, no transmit buffer is validated, no receive buffer is full, the index reads 0, `rx_ready` is 1 and `tx_valid` is 0.
- R2: A write to address 0 loads the index from `mc_wdata` low bits, and a read of address 0 returns it. Control and data port accesses affect only the indexed endpoint.
- R3: At address 1, writing bit 4 as 1 is the clear-receive strobe and writing bit 3 as 1 is the validate strobe. Address 1 always reads 0, and so does unused address 3.
- R4: A data-port write (address 2) with `mc_be`=11 appends two bytes, and with `mc_be`=01 it appends only the low byte; the high byte is stored as 0. The write is ignored when the buffer is validated, when the byte count is odd, or when the count equals `MAX_PKT`.
- R5: The transmit buffer becomes validated in the cycle after a write brings its count to `MAX_PKT`, and not earlier.
- R6: The validate strobe makes a partial packet sendable, including a zero-length one.
- R7: A validated packet goes out as ceil(count/2) beats, or as one beat when the count is 0. The keep field is 11, except 01 on a final odd byte and 00 for a zero-length packet. `tx_last` marks the final beat, and a beat holds stable while `tx_ready` is 0.
- R8: When the final beat is taken, the count returns to 0 and the buffer is no longer validated.
- R9: `rx_ready` equals the inverse of the selected endpoint's receive-full flag. An accepted beat with keep 11 adds 2 bytes and one with keep 01 adds 1 byte. A beat with `rx_last` sets the full flag.
- R10: A data-port read returns the next stored word, with the high byte 0 for a final odd byte. After the last word is read, the buffer clears itself.
- R11: A data-port read of an empty receive buffer returns 0 and changes nothing.
- R12: The clear-receive strobe empties the indexed receive buffer only. Its transmit buffer and the other endpoints stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_wr | input | 1 | Register write strobe |
| mc_rd | input | 1 | Register read strobe (pops the data port) |
| mc_addr | input | 2 | 0 index, 1 control, 2 data port, 3 unused |
| mc_wdata | input | 16 | Write data |
| mc_be | input | 2 | Data port byte enables |
| mc_rdata | output | 16 | Read data, combinational from the current address |
| tk_ep | input | IDXW | Endpoint selected by the token side |
| tx_valid | output | 1 | Transmit beat available |
| tx_ready | input | 1 | Token side takes the beat |
| tx_data | output | 16 | Transmit word |
| tx_keep | output | 2 | Valid bytes in the transmit word |
| tx_last | output | 1 | Final beat of the packet |
| rx_valid | input | 1 | Receive beat offered |
| rx_ready | output | 1 | Receive buffer of `tk_ep` can take data |
| rx_data | input | 16 | Receive word |
| rx_keep | input | 2 | Valid bytes in the receive word |
| rx_last | input | 1 | Final beat of the packet |
| ep_tx_valid | output | NUM_EP | Per-endpoint transmit validated flags |
| ep_rx_full | output | NUM_EP | Per-endpoint receive full flags |

## Verification
A wrong byte count shows on the first packet of an endpoint. Either `ep_tx_valid` rises one write too early or too late, or the last transmit beat carries the wrong keep. Both are visible in the cycle after the write, or at the final beat. A wrong read pointer or a receive flag that fails to clear shows on the next data-port read, or as `rx_ready` staying low. State leaking between endpoints shows as a status bit that changes on an endpoint that was not indexed.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;
  typedef enum logic [1:0] {
    A_INDEX = 2'd0,
    A_CTRL  = 2'd1,
    A_DATA  = 2'd2,
    A_NONE  = 2'd3
  } mc_addr_e;

  localparam int CTL_CLR_RX = 4;
  localparam int CTL_VALID  = 3;
endpackage

// File: rtl/ep_tx_buf.sv
module ep_tx_buf #(
  parameter int MAX_PKT = 64,
  localparam int WORDS = MAX_PKT / 2,
  localparam int LENW  = $clog2(MAX_PKT + 1),
  localparam int PW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic [1:0]  wr_be,
  input  logic        validate,
  input  logic        pop,
  output logic        valid,
  output logic [15:0] out_data,
  output logic [1:0]  out_keep,
  output logic        out_last
);
  logic [15:0]     mem [WORDS];
  logic [LENW-1:0] len;
  logic [PW-1:0]   rdp;
  logic            wr_ok;
  logic [LENW-1:0] nxt_len;
  logic [LENW-1:0] nwords;
  logic [15:0]     wr_word;

  assign wr_ok   = wr_en && !valid && !len[0] && wr_be[0] && (len < LENW'(MAX_PKT));
  assign nxt_len = len + (wr_be[1] ? LENW'(2) : LENW'(1));
  assign wr_word = wr_be[1] ? wr_data : {8'h00, wr_data[7:0]};
  assign nwords  = (len + LENW'(1)) >> 1;

  always_comb begin
    out_last = (len == '0) || (LENW'(rdp) == nwords - LENW'(1));
    out_data = (len == '0) ? 16'h0000 : mem[rdp];
    if (len == '0)              out_keep = 2'b00;
    else if (out_last && len[0]) out_keep = 2'b01;
    else                         out_keep = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[PW'(len >> 1)] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      len   <= '0;
      rdp   <= '0;
    end else if (pop && valid) begin
      if (out_last) begin
        valid <= 1'b0;
        len   <= '0;
        rdp   <= '0;
      end else begin
        rdp <= rdp + PW'(1);
      end
    end else if (wr_ok) begin
      len <= nxt_len;
      if (nxt_len == LENW'(MAX_PKT)) valid <= 1'b1;
    end else if (validate && !valid) begin
      valid <= 1'b1;
    end
  end

  // R4
  tx_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LENW'(MAX_PKT));

  // R4
  tx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && wr_en && !pop) |=> (valid && $stable(len)));

  // R8
  tx_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && valid && out_last) |=> (!valid && len == '0));

  // R5
  tx_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !valid && !pop && wr_be == 2'b11 && len == LENW'(MAX_PKT - 2)) |=> valid);
endmodule

// File: rtl/ep_rx_buf.sv
module ep_rx_buf #(
  parameter int MAX_PKT = 64,
  localparam int WORDS = MAX_PKT / 2,
  localparam int LENW  = $clog2(MAX_PKT + 1),
  localparam int PW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        in_en,
  input  logic [15:0] in_data,
  input  logic [1:0]  in_keep,
  input  logic        in_last,
  input  logic        pop,
  output logic        full,
  output logic [15:0] rd_data
);
  logic [15:0]     mem [WORDS];
  logic [LENW-1:0] len;
  logic [LENW-1:0] wp;
  logic [PW-1:0]   rp;
  logic [LENW-1:0] rem;
  logic [LENW-1:0] nbytes;
  logic            take;
  logic            room;

  assign take = in_en && !full && !clear;
  assign room = wp < LENW'(WORDS);
  assign rem  = len - (LENW'(rp) << 1);

  always_comb begin
    if (in_keep == 2'b11)  nbytes = LENW'(2);
    else if (in_keep[0])   nbytes = LENW'(1);
    else                   nbytes = '0;
  end

  always_comb begin
    if (!full || rem == '0)   rd_data = 16'h0000;
    else if (rem == LENW'(1)) rd_data = {8'h00, mem[rp][7:0]};
    else                      rd_data = mem[rp];
  end

  always_ff @(posedge clk) begin
    if (take && room) mem[PW'(wp)] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      len  <= '0;
      wp   <= '0;
      rp   <= '0;
    end else if (clear) begin
      full <= 1'b0;
      len  <= '0;
      wp   <= '0;
      rp   <= '0;
    end else if (pop && full) begin
      if (rem <= LENW'(2)) begin
        full <= 1'b0;
        len  <= '0;
        wp   <= '0;
        rp   <= '0;
      end else begin
        rp <= rp + PW'(1);
      end
    end else if (take) begin
      if (room) begin
        wp  <= wp + LENW'(1);
        len <= len + nbytes;
      end
      if (in_last) full <= 1'b1;
    end
  end

  // R12
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!full && len == '0));

  // R10
  rx_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop && !clear && rem <= LENW'(2)) |=> !full);

  // R11
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && pop && !in_en && !clear) |=> ($stable(len) && $stable(wp) && !full));

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clear) |=> (full && $stable(len)));
endmodule

// File: rtl/ep_buf_mgr.sv
module ep_buf_mgr
  import ep_buf_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int MAX_PKT = 64,
  localparam int IDXW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_wr,
  input  logic              mc_rd,
  input  logic [1:0]        mc_addr,
  input  logic [15:0]       mc_wdata,
  input  logic [1:0]        mc_be,
  output logic [15:0]       mc_rdata,
  input  logic [IDXW-1:0]   tk_ep,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [15:0]       tx_data,
  output logic [1:0]        tx_keep,
  output logic              tx_last,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [15:0]       rx_data,
  input  logic [1:0]        rx_keep,
  input  logic              rx_last,
  output logic [NUM_EP-1:0] ep_tx_valid,
  output logic [NUM_EP-1:0] ep_rx_full
);
  logic [IDXW-1:0] idx;
  mc_addr_e        addr;
  logic            sel_data_wr;
  logic            sel_data_rd;
  logic            strobe_clr;
  logic            strobe_val;

  logic [15:0] txd  [NUM_EP];
  logic [1:0]  txk  [NUM_EP];
  logic        txl  [NUM_EP];
  logic [15:0] rxd  [NUM_EP];

  assign addr        = mc_addr_e'(mc_addr);
  assign sel_data_wr = mc_wr && (addr == A_DATA);
  assign sel_data_rd = mc_rd && (addr == A_DATA);
  assign strobe_clr  = mc_wr && (addr == A_CTRL) && mc_wdata[CTL_CLR_RX];
  assign strobe_val  = mc_wr && (addr == A_CTRL) && mc_wdata[CTL_VALID];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         idx <= '0;
    else if (mc_wr && addr == A_INDEX)  idx <= mc_wdata[IDXW-1:0];
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit_mc;
    logic hit_tk;
    assign hit_mc = (idx == IDXW'(e));
    assign hit_tk = (tk_ep == IDXW'(e));

    ep_tx_buf #(.MAX_PKT(MAX_PKT)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sel_data_wr && hit_mc),
      .wr_data  (mc_wdata),
      .wr_be    (mc_be),
      .validate (strobe_val && hit_mc),
      .pop      (tx_ready && hit_tk),
      .valid    (ep_tx_valid[e]),
      .out_data (txd[e]),
      .out_keep (txk[e]),
      .out_last (txl[e])
    );

    ep_rx_buf #(.MAX_PKT(MAX_PKT)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (strobe_clr && hit_mc),
      .in_en   (rx_valid && hit_tk),
      .in_data (rx_data),
      .in_keep (rx_keep),
      .in_last (rx_last),
      .pop     (sel_data_rd && hit_mc),
      .full    (ep_rx_full[e]),
      .rd_data (rxd[e])
    );
  end

  assign tx_valid = ep_tx_valid[tk_ep];
  assign tx_data  = txd[tk_ep];
  assign tx_keep  = txk[tk_ep];
  assign tx_last  = txl[tk_ep];
  assign rx_ready = !ep_rx_full[tk_ep];

  always_comb begin
    case (addr)
      A_INDEX: mc_rdata = 16'(idx);
      A_DATA:  mc_rdata = rxd[idx];
      default: mc_rdata = 16'h0000;
    endcase
  end

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_wr && mc_addr == 2'd0) |=> (idx == $past(mc_wdata[IDXW-1:0])));
endmodule

// File: tb/sim_ep_buf_mgr.sv
`timescale 1ns/1ps
module sim_ep_buf_mgr;
  localparam int NEP = 4;
  localparam int MP  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_wr = 0, mc_rd = 0;
  logic [1:0] mc_addr = 0;
  logic [15:0] mc_wdata = 0;
  logic [1:0] mc_be = 0;
  logic [15:0] mc_rdata;
  logic [1:0] tk_ep = 0;
  logic tx_valid, tx_ready = 0;
  logic [15:0] tx_data;
  logic [1:0] tx_keep;
  logic tx_last;
  logic rx_valid = 0, rx_ready;
  logic [15:0] rx_data = 0;
  logic [1:0] rx_keep = 0;
  logic rx_last = 0;
  logic [NEP-1:0] ep_tx_valid, ep_rx_full;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ep_buf_mgr #(.NUM_EP(NEP), .MAX_PKT(MP)) u0 (
    .clk(clk), .rst_n(rst_n), .mc_wr(mc_wr), .mc_rd(mc_rd), .mc_addr(mc_addr),
    .mc_wdata(mc_wdata), .mc_be(mc_be), .mc_rdata(mc_rdata), .tk_ep(tk_ep),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_keep(tx_keep),
    .tx_last(tx_last), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_keep(rx_keep), .rx_last(rx_last), .ep_tx_valid(ep_tx_valid), .ep_rx_full(ep_rx_full)
  );

  // vector: {rd, addr[1:0], data[15:0], be[1:0], exp_rdata[15:0], exp_txv[3:0]}
  localparam int NV = 17;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'h0002, 2'b11, 16'h0000, 4'b0000}, // R2 index 2
    {1'b1, 2'd0, 16'h0000, 2'b11, 16'h0002, 4'b0000}, // R2 read index
    {1'b0, 2'd2, 16'h1234, 2'b11, 16'h0000, 4'b0000}, // R4
    {1'b0, 2'd2, 16'h5678, 2'b11, 16'h0000, 4'b0000}, // R4
    {1'b0, 2'd2, 16'h9ABC, 2'b11, 16'h0000, 4'b0000}, // R5 not yet
    {1'b0, 2'd2, 16'hDEF0, 2'b11, 16'h0000, 4'b0100}, // R5 auto
    {1'b0, 2'd2, 16'hFFFF, 2'b11, 16'h0000, 4'b0100}, // R4 ignored
    {1'b0, 2'd0, 16'h0003, 2'b11, 16'h0000, 4'b0100}, // R2
    {1'b0, 2'd2, 16'h1111, 2'b11, 16'h0000, 4'b0100}, // R4
    {1'b0, 2'd2, 16'h2222, 2'b01, 16'h0000, 4'b0100}, // R4 odd byte
    {1'b0, 2'd2, 16'h3333, 2'b11, 16'h0000, 4'b0100}, // R4 ignored (odd)
    {1'b0, 2'd1, 16'h0008, 2'b00, 16'h0000, 4'b1100}, // R6 short
    {1'b1, 2'd1, 16'h0000, 2'b00, 16'h0000, 4'b1100}, // R3 reads 0
    {1'b0, 2'd0, 16'h0001, 2'b11, 16'h0000, 4'b1100}, // R2
    {1'b0, 2'd1, 16'h0008, 2'b00, 16'h0000, 4'b1110}, // R6 zero length
    {1'b1, 2'd2, 16'h0000, 2'b00, 16'h0000, 4'b1110}, // R11 empty read
    {1'b1, 2'd3, 16'h0000, 2'b00, 16'h0000, 4'b1110}  // R3 unused addr
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic r, input logic [1:0] a,
                     input logic [15:0] d, input logic [1:0] be, output logic [15:0] q);
    @(negedge clk);
    mc_wr = w; mc_rd = r; mc_addr = a; mc_wdata = d; mc_be = be;
    #1 q = mc_rdata;
    @(negedge clk);
    mc_wr = 0; mc_rd = 0;
    #1;
  endtask

  task automatic take(input string tag, input logic [15:0] d, input logic [1:0] k, input logic l);
    @(negedge clk);
    tx_ready = 1;
    #1;
    chk({tag, " tx_valid"}, 16'(tx_valid), 16'h1);
    chk({tag, " tx_data"}, tx_data, d);
    chk({tag, " tx_keep"}, 16'(tx_keep), 16'(k));
    chk({tag, " tx_last"}, 16'(tx_last), 16'(l));
    @(negedge clk);
    tx_ready = 0;
    #1;
  endtask

  task automatic send(input string tag, input logic [15:0] d, input logic [1:0] k, input logic l);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_keep = k; rx_last = l;
    #1 chk({tag, " rx_ready"}, 16'(rx_ready), 16'h1);
    @(negedge clk);
    rx_valid = 0; rx_last = 0;
    #1;
  endtask

  initial begin : watchdog
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog R1 actual %0d expected <20000 cycles", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 ep_tx_valid", 16'(ep_tx_valid), 16'h0);
    chk("R1 ep_rx_full", 16'(ep_rx_full), 16'h0);
    chk("R1 rx_ready", 16'(rx_ready), 16'h1);
    chk("R1 tx_valid", 16'(tx_valid), 16'h0);
    bus(0, 1, 2'd0, 0, 0, q);
    chk("R1 index", q, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      bus(!v[40], v[40], v[39:38], v[37:22], v[21:20], q);
      if (v[40]) chk($sformatf("table %0d rdata (R2 R3 R11)", i), q, v[19:4]);
      chk($sformatf("table %0d ep_tx_valid (R4 R5 R6)", i), 16'(ep_tx_valid), 16'(v[3:0]));
    end

    // R7 full packet on ep2, first held with ready low
    tk_ep = 2;
    @(negedge clk); #1;
    chk("R7 hold data", tx_data, 16'h1234);
    @(negedge clk); #1;
    chk("R7 hold stable", tx_data, 16'h1234);
    take("R7 b0", 16'h1234, 2'b11, 0);
    take("R7 b1", 16'h5678, 2'b11, 0);
    take("R7 b2", 16'h9ABC, 2'b11, 0);
    take("R7 b3", 16'hDEF0, 2'b11, 1);
    chk("R8 ep2 released", 16'(ep_tx_valid), 16'b1010);
    // R7 short packet with odd final byte on ep3
    tk_ep = 3;
    take("R7 short b0", 16'h1111, 2'b11, 0);
    take("R7 short b1", 16'h0022, 2'b01, 1);
    // R7 zero length on ep1
    tk_ep = 1;
    take("R7 zlp", 16'h0000, 2'b00, 1);
    chk("R8 all released", 16'(ep_tx_valid), 16'h0);

    // R8 count restarted at zero: auto validate after exactly MP bytes
    bus(1, 0, 2'd0, 16'h0002, 2'b11, q);
    for (int w = 0; w < 3; w++) bus(1, 0, 2'd2, 16'(w), 2'b11, q);
    chk("R8 not early", 16'(ep_tx_valid[2]), 16'h0);
    bus(1, 0, 2'd2, 16'hAAAA, 2'b11, q);
    chk("R8 revalidated", 16'(ep_tx_valid[2]), 16'h1);

    // R9 R10 receive 3-byte packet on ep0
    tk_ep = 0;
    send("R9 b0", 16'hA1B2, 2'b11, 0);
    chk("R9 not full mid", 16'(ep_rx_full), 16'h0);
    send("R9 b1", 16'h77C3, 2'b01, 1);
    chk("R9 full", 16'(ep_rx_full), 16'b0001);
    chk("R9 rx_ready low", 16'(rx_ready), 16'h0);
    bus(1, 0, 2'd0, 16'h0000, 2'b11, q);
    bus(0, 1, 2'd2, 0, 0, q);
    chk("R10 word0", q, 16'hA1B2);
    chk("R10 still full", 16'(ep_rx_full), 16'b0001);
    bus(0, 1, 2'd2, 0, 0, q);
    chk("R10 odd word", q, 16'h00C3);
    chk("R10 auto clear", 16'(ep_rx_full), 16'h0);
    bus(0, 1, 2'd2, 0, 0, q);
    chk("R11 empty read", q, 16'h0000);

    // R12 clear strobe: rx only, indexed only
    bus(1, 0, 2'd2, 16'h5555, 2'b11, q);
    bus(1, 0, 2'd1, 16'h0008, 2'b00, q);
    chk("R12 ep0 tx set", 16'(ep_tx_valid[0]), 16'h1);
    for (int b = 0; b < 4; b++) send("R12 fill", 16'h0101 * 16'(b + 1), 2'b11, b == 3);
    tk_ep = 1;
    send("R12 ep1", 16'h4242, 2'b11, 1);
    chk("R12 both full", 16'(ep_rx_full), 16'b0011);
    bus(1, 0, 2'd1, 16'h0010, 2'b00, q);
    chk("R12 ep0 cleared only", 16'(ep_rx_full), 16'b0010);
    chk("R12 tx untouched", 16'(ep_tx_valid[0]), 16'h1);
    tk_ep = 0;
    #1 chk("R12 rx_ready back", 16'(rx_ready), 16'h1);
    bus(0, 1, 2'd2, 0, 0, q);
    chk("R12 cleared read", q, 16'h0000);
    bus(1, 0, 2'd0, 16'h0001, 2'b11, q);
    bus(0, 1, 2'd2, 0, 0, q);
    chk("R2 ep1 word", q, 16'h4242);
    chk("R10 ep1 cleared", 16'(ep_rx_full), 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule